// File: doc/BRIEF.md
# Repeated String Operation Sequencer

This block steps one string operation through a repeat loop. A single start command chooses the operation (load, store, move, compare or scan), the repeat prefix, the element size, the direction and the address size. The command also supplies the first values of the count register and of the source and destination index registers. The block then issues one element access per iteration and waits for the memory side to accept it. After each accepted access it moves the index registers that the operation uses and, when a repeat prefix is present, decrements the count.

The loop ends in one of two ways. The first is count exhaustion, which applies to every repeated operation. The second applies only to compare and scan: a zero-flag condition, sampled with each accepted access, that stops the loop. A one-cycle done pulse carries the cause of the stop. The address size picks either the full registers or only their low halves. Behaviour follows the address size, never the operand size. The data comparison itself is outside the block, and only its zero flag arrives here.

Top module: `strop_repeat_seq`

## Requirements
- R1: While reset is low at a clock edge, and at the first sample after it, `busy`, `done`, `mem_req` and `done_by_flag` are 0, and `cnt_q`, `src_q` and `dst_q` are 0.
- R2: A `start` sampled while idle loads `cnt_in`, `src_in` and `dst_in` into the registers. If the loop is not skipped (R5), `mem_req` is high from the next cycle onward.
- R3: Each accepted access (`mem_req` and `mem_ready` both high at an edge) steps the used index registers by 1, 2 or 4 bytes for `elem_size` codes 0, 1 and 2 (code 3 also means 4). The step subtracts when `dir_flag`=1 and adds otherwise. Codes for `op_code`: load=0 moves the source only; store=1 moves the destination only; move=2 and compare=3 move both; scan=4 moves the destination only; codes 5 to 7 behave as load.
- R4: Under `rep_code` 1 or 2 with a non-compare operation, the loop runs exactly as many accesses as the starting count and ends with the count at zero. `zf_in` has no effect, and `done_by_flag` is 0.
- R5: If a repeat prefix is present and the count selected by the address size is zero at start, no access is issued. `done` pulses on the cycle after start, and all registers keep their loaded values.
- R6: For compare and scan, `rep_code`=1 stops after an accepted access with `zf_in`=0, and `rep_code`=2 stops after an accepted access with `zf_in`=1. The count is still decremented for that access, and `done_by_flag` is 1.
- R7: When the flag condition stops a loop on the same access that empties the count, `done_by_flag` is 1. When the count empties while the flag condition still holds, it is 0.
- R8: With `addr32`=0, only bits 15:0 of the count and index registers change, and they wrap within 16 bits. The upper bits keep their loaded values, and the zero test on the count uses bits 15:0 only. With `addr32`=1, the full 32 bits are used.
- R9: With `rep_code` 0 or 3 (no repeat), exactly one access is issued, whatever the count. The count register is left unchanged, and `done_by_flag` is 0.
- R10: While `mem_req` is high and `mem_ready` is low, the count and index registers hold their values.
- R11: `done` lasts exactly one cycle, and `busy` is high from the cycle after start until the cycle after `done`. A `start` seen while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a new operation (taken only while idle) |
| op_code | input | 3 | Operation: 0 load, 1 store, 2 move, 3 compare, 4 scan |
| rep_code | input | 2 | 0 none, 1 repeat-while-equal / plain repeat, 2 repeat-while-not-equal, 3 none |
| elem_size | input | 2 | Element size: 0 byte, 1 two bytes, 2 or 3 four bytes |
| dir_flag | input | 1 | 1 = indices count down |
| addr32 | input | 1 | 1 = 32-bit count and indices, 0 = low 16 bits only |
| cnt_in | input | 32 | Starting count |
| src_in | input | 32 | Starting source index |
| dst_in | input | 32 | Starting destination index |
| mem_ready | input | 1 | Memory accepts the pending access |
| zf_in | input | 1 | Zero flag of the current compare/scan element, valid with `mem_ready` |
| mem_req | output | 1 | Element access pending |
| mem_kind | output | 3 | Operation code of the pending access |
| mem_size | output | 2 | Element size code of the pending access |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| done_by_flag | output | 1 | With `done`: loop ended by the zero-flag condition |
| cnt_q | output | 32 | Count register |
| src_q | output | 32 | Source index register (address of a read) |
| dst_q | output | 32 | Destination index register (address of a write) |

## Verification
On every cycle, the assertions check several properties. The registers hold while an access waits. A count decrement is exactly one, and the count stays put when no prefix is present. The upper halves do not move in 16-bit mode. A start is followed by a request, or by an immediate done when the count is zero. Done never lasts two cycles. Only the bench's scenarios can show the rest. These are the number of accesses a loop makes and the final values after mixed sizes and directions. They also cover the choice of stop cause when the flag fails on the last count, 16-bit wrap-around, the behaviour of the reserved prefix code, and a start ignored while busy, all under a memory side that inserts varying wait cycles.

// File: rtl/strop_pkg.sv
// Package: shared codes and the latched command type for the string
// operation sequencer. Assumes op and prefix codes arrive as plain vectors.
package strop_pkg;

    localparam int OP_W   = 3;
    localparam int REP_W  = 2;
    localparam int SIZE_W = 2;

    localparam logic [OP_W-1:0] OP_LOAD  = 3'd0;
    localparam logic [OP_W-1:0] OP_STORE = 3'd1;
    localparam logic [OP_W-1:0] OP_MOVE  = 3'd2;
    localparam logic [OP_W-1:0] OP_CMP   = 3'd3;
    localparam logic [OP_W-1:0] OP_SCAN  = 3'd4;

    localparam logic [REP_W-1:0] REP_NONE = 2'd0;
    localparam logic [REP_W-1:0] REP_EQ   = 2'd1;
    localparam logic [REP_W-1:0] REP_NE   = 2'd2;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACCESS = 2'd1,
        ST_FIN    = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic [OP_W-1:0]   op;
        logic [REP_W-1:0]  rep;
        logic [SIZE_W-1:0] size;
        logic              dir;
        logic              a32;
    } seq_cmd_t;

    // True when the prefix asks for repetition.
    function automatic logic rep_active(logic [REP_W-1:0] rep);
        return (rep == REP_EQ) || (rep == REP_NE);
    endfunction

    // True for operations whose loop may also stop on the zero flag.
    function automatic logic op_is_compare(logic [OP_W-1:0] op);
        return (op == OP_CMP) || (op == OP_SCAN);
    endfunction

    // True for operations that advance the destination index.
    function automatic logic op_moves_dst(logic [OP_W-1:0] op);
        return (op == OP_STORE) || (op == OP_MOVE) || (op == OP_CMP) || (op == OP_SCAN);
    endfunction

    // True for operations that advance the source index (reserved codes act as load).
    function automatic logic op_moves_src(logic [OP_W-1:0] op);
        return !((op == OP_STORE) || (op == OP_SCAN));
    endfunction

endpackage

// File: rtl/strop_step_gen.sv
// Step generator: turns element size and direction into a signed index
// delta of DATA_W bits. Assumes size code 3 is treated as four bytes.
module strop_step_gen
    import strop_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [SIZE_W-1:0] size_code,
    input  logic              dir_down,
    output logic [DATA_W-1:0] delta
);
    localparam logic [DATA_W-1:0] ONE_B  = DATA_W'(1);
    localparam logic [DATA_W-1:0] TWO_B  = DATA_W'(2);
    localparam logic [DATA_W-1:0] FOUR_B = DATA_W'(4);

    logic [DATA_W-1:0] mag;

    // Pick the element byte count, then negate it for downward stepping.
    always_comb begin
        unique case (size_code)
            2'd0:    mag = ONE_B;
            2'd1:    mag = TWO_B;
            default: mag = FOUR_B;
        endcase
        delta = dir_down ? (~mag + ONE_B) : mag;
    end
endmodule

// File: rtl/strop_term_eval.sv
// Termination evaluator: decides, for an accepted access, whether the loop
// stops and whether the zero-flag condition caused it. Assumes zf is valid
// whenever the access is accepted.
module strop_term_eval
    import strop_pkg::*;
(
    input  logic [OP_W-1:0]  op,
    input  logic [REP_W-1:0] rep,
    input  logic             cnt_next_zero,
    input  logic             zf,
    output logic             finish,
    output logic             by_flag
);
    logic repeating;
    logic flag_stop;

    // Combine the count-only and the flag-polarity stop rules.
    always_comb begin
        repeating = rep_active(rep);
        flag_stop = repeating && op_is_compare(op) &&
                    (((rep == REP_EQ) && !zf) || ((rep == REP_NE) && zf));
        finish    = !repeating || cnt_next_zero || flag_stop;
        by_flag   = flag_stop;
    end
endmodule

// File: rtl/strop_idx_regs.sv
// Register file for the count and the two index registers. Loads on start,
// updates on an accepted access, and merges only the low LO_W bits when
// the latched address size is narrow. Assumes load and adv never coincide.
module strop_idx_regs #(
    parameter int DATA_W = 32,
    parameter int LO_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              load_a32,
    input  logic [DATA_W-1:0] cnt_in,
    input  logic [DATA_W-1:0] src_in,
    input  logic [DATA_W-1:0] dst_in,
    input  logic              adv,
    input  logic              a32,
    input  logic              upd_cnt,
    input  logic              upd_src,
    input  logic              upd_dst,
    input  logic [DATA_W-1:0] delta,
    output logic [DATA_W-1:0] cnt_q,
    output logic [DATA_W-1:0] src_q,
    output logic [DATA_W-1:0] dst_q,
    output logic              cnt_load_zero,
    output logic              cnt_next_zero
);
    localparam int NUM_IDX = 2;
    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);
    localparam logic [LO_W-1:0]   LO_ONE = LO_W'(1);

    // Keep the upper bits of old when the address size is narrow.
    function automatic logic [DATA_W-1:0] merge(logic [DATA_W-1:0] old_v,
                                                logic [DATA_W-1:0] new_v,
                                                logic wide);
        return wide ? new_v : {old_v[DATA_W-1:LO_W], new_v[LO_W-1:0]};
    endfunction

    logic [DATA_W-1:0] idx_in   [NUM_IDX];
    logic [DATA_W-1:0] idx_q    [NUM_IDX];
    logic              idx_upd  [NUM_IDX];

    assign idx_in[0]  = src_in;
    assign idx_in[1]  = dst_in;
    assign idx_upd[0] = upd_src;
    assign idx_upd[1] = upd_dst;
    assign src_q      = idx_q[0];
    assign dst_q      = idx_q[1];

    // Zero tests on the incoming count and on the count after one decrement.
    always_comb begin
        cnt_load_zero = load_a32 ? (cnt_in == '0) : (cnt_in[LO_W-1:0] == '0);
        cnt_next_zero = a32 ? (cnt_q == ONE) : (cnt_q[LO_W-1:0] == LO_ONE);
    end

    // Count register: load, or decrement once per accepted repeated access.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= cnt_in;
        else if (adv && upd_cnt)
            cnt_q <= merge(cnt_q, cnt_q - ONE, a32);
    end

    genvar gi;
    generate
        for (gi = 0; gi < NUM_IDX; gi++) begin : g_idx
            // Index register: load, or step by delta on an accepted access.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    idx_q[gi] <= '0;
                else if (load)
                    idx_q[gi] <= idx_in[gi];
                else if (adv && idx_upd[gi])
                    idx_q[gi] <= merge(idx_q[gi], idx_q[gi] + delta, a32);
            end

            // R8: narrow address size never touches the upper index bits
            a_r8_idx_upper: assert property (@(posedge clk) disable iff (!rst_n)
                (!load && !a32) |=> (idx_q[gi][DATA_W-1:LO_W] == $past(idx_q[gi][DATA_W-1:LO_W])));
        end
    endgenerate

    // R10: registers hold while no access is accepted and nothing loads
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !adv) |=> ($stable(cnt_q) && $stable(src_q) && $stable(dst_q)));

    // R4: a repeated access lowers the full-width count by exactly one
    a_r4_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && upd_cnt && a32) |=> (cnt_q == $past(cnt_q) - ONE));

    // R9: without a prefix the count is left alone
    a_r9_count_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !upd_cnt) |=> $stable(cnt_q));

    // R8: narrow address size never touches the upper count bits
    a_r8_cnt_upper: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !a32) |=> (cnt_q[DATA_W-1:LO_W] == $past(cnt_q[DATA_W-1:LO_W])));
endmodule

// File: rtl/strop_fsm.sv
// Iteration controller: accepts a start while idle, latches the command,
// holds the access request until memory is ready, and ends with a one-cycle
// done carrying the stop cause. Assumes finish/by_flag come from the
// termination evaluator for the access being accepted.
module strop_fsm
    import strop_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  seq_cmd_t    cmd_in,
    input  logic        cnt_load_zero,
    input  logic        mem_ready,
    input  logic        finish,
    input  logic        by_flag,
    output seq_cmd_t    cmd_q,
    output logic        load,
    output logic        adv,
    output logic        mem_req,
    output logic        busy,
    output logic        done,
    output logic        done_by_flag
);
    seq_state_e state_q, state_d;
    logic       skip;
    logic       flag_q;

    // Decode accepted start, zero-count skip and accepted access.
    always_comb begin
        load = (state_q == ST_IDLE) && start;
        skip = rep_active(cmd_in.rep) && cnt_load_zero;
        adv  = (state_q == ST_ACCESS) && mem_ready;
    end

    // Next-state selection for the iteration loop.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = skip ? ST_FIN : ST_ACCESS;
            ST_ACCESS: if (mem_ready && finish) state_d = ST_FIN;
            ST_FIN:    state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State, latched command and stop-cause registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cmd_q   <= '0;
            flag_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (load) begin
                cmd_q  <= cmd_in;
                flag_q <= 1'b0;
            end else if (adv && finish) begin
                flag_q <= by_flag;
            end
        end
    end

    assign mem_req      = (state_q == ST_ACCESS);
    assign busy         = (state_q != ST_IDLE);
    assign done         = (state_q == ST_FIN);
    assign done_by_flag = done && flag_q;

    // R2: a start that is not skipped raises the request next cycle
    a_r2_req_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !skip) |=> mem_req);

    // R5: a zero-count repeated start ends without any access
    a_r5_zero_skip: assert property (@(posedge clk) disable iff (!rst_n)
        (load && skip) |=> (done && !mem_req && !done_by_flag));

    // R11: done is a single-cycle pulse
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11: a start during a run leaves the latched command alone
    a_r11_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(cmd_q));
endmodule

// File: rtl/strop_repeat_seq.sv
// Top of the repeated string operation sequencer. Wires the controller,
// the step generator, the termination evaluator and the register file.
// Assumes a memory side that answers each request with mem_ready and,
// for compare and scan, a zero flag valid in the same cycle.
module strop_repeat_seq
    import strop_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LO_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        op_code,
    input  logic [1:0]        rep_code,
    input  logic [1:0]        elem_size,
    input  logic              dir_flag,
    input  logic              addr32,
    input  logic [DATA_W-1:0] cnt_in,
    input  logic [DATA_W-1:0] src_in,
    input  logic [DATA_W-1:0] dst_in,
    input  logic              mem_ready,
    input  logic              zf_in,
    output logic              mem_req,
    output logic [2:0]        mem_kind,
    output logic [1:0]        mem_size,
    output logic              busy,
    output logic              done,
    output logic              done_by_flag,
    output logic [DATA_W-1:0] cnt_q,
    output logic [DATA_W-1:0] src_q,
    output logic [DATA_W-1:0] dst_q
);
    seq_cmd_t          cmd_in;
    seq_cmd_t          cmd_q;
    logic              load;
    logic              adv;
    logic              finish;
    logic              by_flag;
    logic              cnt_load_zero;
    logic              cnt_next_zero;
    logic [DATA_W-1:0] delta;

    // Pack the start command fields.
    always_comb begin
        cmd_in.op   = op_code;
        cmd_in.rep  = rep_code;
        cmd_in.size = elem_size;
        cmd_in.dir  = dir_flag;
        cmd_in.a32  = addr32;
    end

    assign mem_kind = cmd_q.op;
    assign mem_size = cmd_q.size;

    strop_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start),
        .cmd_in        (cmd_in),
        .cnt_load_zero (cnt_load_zero),
        .mem_ready     (mem_ready),
        .finish        (finish),
        .by_flag       (by_flag),
        .cmd_q         (cmd_q),
        .load          (load),
        .adv           (adv),
        .mem_req       (mem_req),
        .busy          (busy),
        .done          (done),
        .done_by_flag  (done_by_flag)
    );

    strop_step_gen #(.DATA_W(DATA_W)) u_step (
        .size_code (cmd_q.size),
        .dir_down  (cmd_q.dir),
        .delta     (delta)
    );

    strop_term_eval u_term (
        .op            (cmd_q.op),
        .rep           (cmd_q.rep),
        .cnt_next_zero (cnt_next_zero),
        .zf            (zf_in),
        .finish        (finish),
        .by_flag       (by_flag)
    );

    strop_idx_regs #(.DATA_W(DATA_W), .LO_W(LO_W)) u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .load          (load),
        .load_a32      (addr32),
        .cnt_in        (cnt_in),
        .src_in        (src_in),
        .dst_in        (dst_in),
        .adv           (adv),
        .a32           (cmd_q.a32),
        .upd_cnt       (rep_active(cmd_q.rep)),
        .upd_src       (op_moves_src(cmd_q.op)),
        .upd_dst       (op_moves_dst(cmd_q.op)),
        .delta         (delta),
        .cnt_q         (cnt_q),
        .src_q         (src_q),
        .dst_q         (dst_q),
        .cnt_load_zero (cnt_load_zero),
        .cnt_next_zero (cnt_next_zero)
    );

    // R6: a flag-caused stop only happens on a repeated compare or scan
    a_r6_flag_scope: assert property (@(posedge clk) disable iff (!rst_n)
        done_by_flag |-> (rep_active(cmd_q.rep) && op_is_compare(cmd_q.op)));
endmodule

// File: tb/strop_repeat_seq_tb_top.sv
// Bench: walks a table of commands with expected results under a memory
// side that inserts 0..2 wait cycles, then runs directed reset and busy tests.
module strop_repeat_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DW         = 32;
    localparam int NVEC       = 14;
    localparam int WATCHDOG   = 20000;

    typedef struct packed {
        logic [2:0]    op;
        logic [1:0]    rep;
        logic [1:0]    sz;
        logic          dir;
        logic          a32;
        logic [DW-1:0] cnt;
        logic [DW-1:0] src;
        logic [DW-1:0] dst;
        logic [15:0]   zpat;
        logic [7:0]    e_acc;
        logic [DW-1:0] e_cnt;
        logic [DW-1:0] e_src;
        logic [DW-1:0] e_dst;
        logic          e_flag;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        // R3/R4: move, 2-byte up
        '{3'd2, 2'd1, 2'd1, 1'b0, 1'b1, 32'd3, 32'h1000, 32'h2000, 16'h0000, 8'd3, 32'd0, 32'h1006, 32'h2006, 1'b0},
        // R3/R4: load, 4-byte down, destination untouched
        '{3'd0, 2'd1, 2'd2, 1'b1, 1'b1, 32'd4, 32'h100, 32'h500, 16'h0000, 8'd4, 32'd0, 32'hF0, 32'h500, 1'b0},
        // R8: store, 16-bit wrap, upper count bits kept
        '{3'd1, 2'd1, 2'd0, 1'b0, 1'b0, 32'hABCD0002, 32'h11, 32'h7777FFFF, 16'h0000, 8'd2, 32'hABCD0000, 32'h11, 32'h77770001, 1'b0},
        // R6: compare while equal, flag fails on third
        '{3'd3, 2'd1, 2'd0, 1'b0, 1'b1, 32'd10, 32'h40, 32'h80, 16'h0003, 8'd3, 32'd7, 32'h43, 32'h83, 1'b1},
        // R6: scan while not equal, flag set on third
        '{3'd4, 2'd2, 2'd1, 1'b1, 1'b1, 32'd5, 32'h999, 32'h300, 16'h0004, 8'd3, 32'd2, 32'h999, 32'h2FA, 1'b1},
        // R7: compare, count empties with flag holding
        '{3'd3, 2'd1, 2'd2, 1'b0, 1'b1, 32'd2, 32'h10, 32'h20, 16'hFFFF, 8'd2, 32'd0, 32'h18, 32'h28, 1'b0},
        // R7: flag fails on the last count
        '{3'd3, 2'd1, 2'd0, 1'b1, 1'b1, 32'd1, 32'h10, 32'h20, 16'h0000, 8'd1, 32'd0, 32'hF, 32'h1F, 1'b1},
        // R9: no prefix with zero count runs once
        '{3'd2, 2'd0, 2'd2, 1'b0, 1'b1, 32'd0, 32'h100, 32'h200, 16'h0000, 8'd1, 32'd0, 32'h104, 32'h204, 1'b0},
        // R5: repeated zero count is a no-op
        '{3'd2, 2'd1, 2'd2, 1'b0, 1'b1, 32'd0, 32'h100, 32'h200, 16'h0000, 8'd0, 32'd0, 32'h100, 32'h200, 1'b0},
        // R9: prefix code 3 acts as none, 16-bit down wrap
        '{3'd0, 2'd3, 2'd1, 1'b1, 1'b0, 32'd7, 32'h12340000, 32'h9, 16'h0000, 8'd1, 32'd7, 32'h1234FFFE, 32'h9, 1'b0},
        // R8/R5: low 16 bits zero means no-op in 16-bit mode
        '{3'd4, 2'd1, 2'd0, 1'b0, 1'b0, 32'hFFFF0000, 32'h6, 32'h5, 16'h0000, 8'd0, 32'hFFFF0000, 32'h6, 32'h5, 1'b0},
        // R8: move 4-byte down, 16-bit wrap on both indices
        '{3'd2, 2'd1, 2'd2, 1'b1, 1'b0, 32'h00010003, 32'h00020004, 32'h00030002, 16'h0000, 8'd3, 32'h00010000, 32'h0002FFF8, 32'h0003FFF6, 1'b0},
        // R6/R7: scan while not equal, never matches, count ends
        '{3'd4, 2'd2, 2'd0, 1'b0, 1'b1, 32'd3, 32'h50, 32'h0, 16'h0000, 8'd3, 32'd0, 32'h50, 32'h3, 1'b0},
        // R4: store under prefix 2 ignores zf
        '{3'd1, 2'd2, 2'd0, 1'b0, 1'b1, 32'd2, 32'h0, 32'h10, 16'hFFFF, 8'd2, 32'd0, 32'h0, 32'h12, 1'b0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [2:0]    op_code = '0;
    logic [1:0]    rep_code = '0;
    logic [1:0]    elem_size = '0;
    logic          dir_flag = 1'b0;
    logic          addr32 = 1'b0;
    logic [DW-1:0] cnt_in = '0;
    logic [DW-1:0] src_in = '0;
    logic [DW-1:0] dst_in = '0;
    logic          mem_ready = 1'b0;
    logic          zf_in = 1'b0;
    logic          mem_req;
    logic [2:0]    mem_kind;
    logic [1:0]    mem_size;
    logic          busy;
    logic          done;
    logic          done_by_flag;
    logic [DW-1:0] cnt_q;
    logic [DW-1:0] src_q;
    logic [DW-1:0] dst_q;

    int n_checks = 0;
    int n_fails  = 0;
    logic finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    strop_repeat_seq #(.DATA_W(DW), .LO_W(16)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .op_code(op_code),
        .rep_code(rep_code), .elem_size(elem_size), .dir_flag(dir_flag),
        .addr32(addr32), .cnt_in(cnt_in), .src_in(src_in), .dst_in(dst_in),
        .mem_ready(mem_ready), .zf_in(zf_in), .mem_req(mem_req),
        .mem_kind(mem_kind), .mem_size(mem_size), .busy(busy), .done(done),
        .done_by_flag(done_by_flag), .cnt_q(cnt_q), .src_q(src_q), .dst_q(dst_q)
    );

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Apply one table entry and wait for its done pulse.
    task automatic run_vec(input int vi);
        vec_t v = VECS[vi];
        int nacc = 0;
        int waitc = 0;
        int cyc = 0;
        logic got_done = 1'b0;
        logic got_flag = 1'b0;
        op_code = v.op; rep_code = v.rep; elem_size = v.sz; dir_flag = v.dir;
        addr32 = v.a32; cnt_in = v.cnt; src_in = v.src; dst_in = v.dst;
        start = 1'b1;
        forever begin
            @(negedge clk);
            cyc++;
            start = 1'b0;
            if (mem_ready) begin
                nacc++;
                waitc = 0;
            end
            mem_ready = 1'b0;
            if (done) begin
                got_done = 1'b1;
                got_flag = done_by_flag;
                break;
            end
            if (cyc > 200) break;
            if (mem_req) begin
                if (waitc >= (nacc % 3)) begin
                    mem_ready = 1'b1;
                    zf_in = v.zpat[nacc % 16];
                end else begin
                    waitc++;
                end
            end
        end
        chk($sformatf("R11 vec%0d done seen", vi), DW'(got_done), DW'(1));
        chk($sformatf("R4/R5/R9 vec%0d access count", vi), DW'(nacc), DW'(v.e_acc));
        chk($sformatf("R4/R6/R8 vec%0d count", vi), cnt_q, v.e_cnt);
        chk($sformatf("R3/R8 vec%0d source", vi), src_q, v.e_src);
        chk($sformatf("R3/R8 vec%0d destination", vi), dst_q, v.e_dst);
        chk($sformatf("R6/R7 vec%0d stop cause", vi), DW'(got_flag), DW'(v.e_flag));
        @(negedge clk);
        chk($sformatf("R11 vec%0d done pulse ends", vi), {30'd0, done, busy}, '0);
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R1: state during and right after reset
        chk("R1 outputs in reset", {28'd0, busy, done, mem_req, done_by_flag}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 count after reset", cnt_q, '0);
        chk("R1 source after reset", src_q, '0);
        chk("R1 destination after reset", dst_q, '0);
        chk("R1 control after reset", {28'd0, busy, done, mem_req, done_by_flag}, '0);

        for (int i = 0; i < NVEC; i++) run_vec(i);

        // R2/R10/R11: start while busy is ignored; registers hold while waiting
        op_code = 3'd2; rep_code = 2'd1; elem_size = 2'd0; dir_flag = 1'b0;
        addr32 = 1'b1; cnt_in = 32'd2; src_in = 32'h0; dst_in = 32'h40;
        start = 1'b1;
        @(negedge clk);
        chk("R2 request after start", {30'd0, mem_req, busy}, 32'd3);
        chk("R2 count loaded", cnt_q, 32'd2);
        op_code = 3'd0; cnt_in = 32'd9; src_in = 32'h77; dst_in = 32'h88;
        repeat (3) @(negedge clk);
        start = 1'b0;
        chk("R11 start while busy ignored", cnt_q, 32'd2);
        chk("R10 source holds while waiting", src_q, 32'h0);
        chk("R11 kind unchanged", DW'(mem_kind), 32'd2);
        mem_ready = 1'b1;
        @(negedge clk);
        chk("R10 one step after ready", cnt_q, 32'd1);
        @(negedge clk);
        mem_ready = 1'b0;
        chk("R11 done after last access", {31'd0, done}, 32'd1);
        chk("R3 move steps both", {src_q[15:0], dst_q[15:0]}, {16'h0002, 16'h0042});
        @(negedge clk);
        chk("R11 done lasts one cycle", {30'd0, done, busy}, '0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule